// File: doc/BRIEF.md
# 100BASE-TX Transmit Code-Group Encoder with Stream Delimiters

This block is the transmit code-group stage of a 100 Mb/s physical coding sublayer. Each clock it takes one nibble from the MAC side, together with a transmit-enable and a transmit-error flag, and produces one 5-bit code group. Its output goes to a scrambler, which lies outside this block. Outside a frame it sends the idle group. When a frame starts, it swaps the first two nibbles, which are preamble, for the start-of-stream delimiter pair. Each later nibble is mapped through the 4B/5B data table. When the enable falls, it appends the end-of-stream delimiter pair. An error flag raised during the data phase turns the current nibble into the halt group.

A bypass input turns off the framing. In bypass, a raw 5-bit group passes straight to the output with the same one-clock latency, and the framing state machine is held in its idle state.

The controller is a four-state machine. The states are IDLE, SEND_K, DATA and SEND_R, and every output is registered once. The transitions are:
- IDLE to SEND_K when enable is high (J is emitted).
- SEND_K to DATA when enable is high (K is emitted).
- SEND_K to SEND_R when enable is low (T is emitted).
- DATA stays in DATA while enable is high (data or halt is emitted).
- DATA to SEND_R when enable falls (T is emitted).
- SEND_R to IDLE unconditionally (R is emitted).
- Any state to IDLE while bypass is high.

Top module: `pcs_tx_cg_encoder`

## Requirements
- R1: While reset is asserted, and in the first sample after it, `code_out` is 11111 and the controller is in IDLE.
- R2: Outside a frame, with `tx_en` low and bypass low, `code_out` is the idle group 11111 on every clock.
- R3: A frame opens on the first clock with `tx_en` high in IDLE. That clock and the next produce J (11000) and then K (10001) one clock later, and the nibble values on those two clocks are discarded.
- R4: After K, each nibble with `tx_en` high appears one clock later as its 4B/5B group. The mapping is:
  - 0 to 11110, 1 to 01001, 2 to 10100, 3 to 10101
  - 4 to 01010, 5 to 01011, 6 to 01110, 7 to 01111
  - 8 to 10010, 9 to 10011, A to 10110, B to 10111
  - C to 11010, D to 11011, E to 11100, F to 11101
- R5: The first clock with `tx_en` low after the data phase produces T (01101). The following clock produces R (00111), and idle follows after that.
- R6: In the data phase, `tx_er` high together with `tx_en` produces the halt group 00100 in place of that nibble, and the frame continues.
- R7: If `tx_en` falls on the clock where K would be produced, T is produced instead, followed by R and then idle.
- R8: `tx_en` on the clock that produces R is ignored: R is still sent. If `tx_en` is still high on the next clock, a new frame opens with J.
- R9: `tx_er` is ignored on the two start-delimiter clocks: J and K are sent unchanged.
- R10: With `bypass` high, `code_out` equals `raw_cg` from the previous clock. After bypass drops, framing restarts from IDLE: idle is sent if `tx_en` is low, and J if it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame enable from the MAC side |
| tx_er | input | 1 | Transmit error flag |
| txd | input | 4 | Transmit nibble |
| bypass | input | 1 | Pass `raw_cg` through unencoded |
| raw_cg | input | 5 | Raw code group used in bypass |
| code_out | output | 5 | Registered 5-bit code group |

## Verification
A wrong state in the controller shows up in the very next code group, because each state maps directly to a delimiter or a data group.

Some faults and how they appear at the output:
- A missed IDLE to SEND_K step appears as a data group where K belongs.
- A missing SEND_R state shows as idle directly after T.
- A controller stuck in DATA keeps emitting data groups after the enable falls.

Each of these is visible one clock after the offending input, so every check samples exactly one clock after the stimulus.

// File: rtl/pcs_tx_cg_pkg.sv
package pcs_tx_cg_pkg;

    localparam int NIB_W = 4;
    localparam int CG_W  = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND_K,
        ST_DATA,
        ST_SEND_R
    } txcg_state_e;

    typedef enum logic [2:0] {
        SEL_IDLE,
        SEL_J,
        SEL_K,
        SEL_DATA,
        SEL_HALT,
        SEL_T,
        SEL_R
    } cg_sel_e;

    localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [CG_W-1:0] CG_J    = 5'b11000;
    localparam logic [CG_W-1:0] CG_K    = 5'b10001;
    localparam logic [CG_W-1:0] CG_T    = 5'b01101;
    localparam logic [CG_W-1:0] CG_R    = 5'b00111;
    localparam logic [CG_W-1:0] CG_HALT = 5'b00100;

endpackage

// File: rtl/txcg_nibble_map.sv
module txcg_nibble_map
    import pcs_tx_cg_pkg::*;
#(
    parameter int NW = NIB_W,
    parameter int CW = CG_W
) (
    input  logic [NW-1:0] nib,
    output logic [CW-1:0] cg
);

    // Data group table (R4)
    always_comb begin
        unique case (nib)
            4'h0: cg = 5'b11110;
            4'h1: cg = 5'b01001;
            4'h2: cg = 5'b10100;
            4'h3: cg = 5'b10101;
            4'h4: cg = 5'b01010;
            4'h5: cg = 5'b01011;
            4'h6: cg = 5'b01110;
            4'h7: cg = 5'b01111;
            4'h8: cg = 5'b10010;
            4'h9: cg = 5'b10011;
            4'hA: cg = 5'b10110;
            4'hB: cg = 5'b10111;
            4'hC: cg = 5'b11010;
            4'hD: cg = 5'b11011;
            4'hE: cg = 5'b11100;
            default: cg = 5'b11101;
        endcase
    end

endmodule

// File: rtl/txcg_delim_fsm.sv
module txcg_delim_fsm
    import pcs_tx_cg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_en,
    input  logic        tx_er,
    input  logic        bypass,
    output txcg_state_e state_q,
    output cg_sel_e     sel
);

    txcg_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state and group selection
    always_comb begin
        state_d = state_q;
        sel     = SEL_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_en) begin
                    sel     = SEL_J;
                    state_d = ST_SEND_K;
                end
            end
            ST_SEND_K: begin
                if (tx_en) begin
                    sel     = SEL_K;
                    state_d = ST_DATA;
                end else begin
                    sel     = SEL_T;
                    state_d = ST_SEND_R;
                end
            end
            ST_DATA: begin
                if (tx_en) begin
                    sel = tx_er ? SEL_HALT : SEL_DATA;
                end else begin
                    sel     = SEL_T;
                    state_d = ST_SEND_R;
                end
            end
            ST_SEND_R: begin
                sel     = SEL_R;
                state_d = ST_IDLE;
            end
            default: begin
                sel     = SEL_IDLE;
                state_d = ST_IDLE;
            end
        endcase
        if (bypass) state_d = ST_IDLE;
    end

endmodule

// File: rtl/txcg_out_reg.sv
module txcg_out_reg #(
    parameter int           W       = 5,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

endmodule

// File: rtl/pcs_tx_cg_encoder.sv
module pcs_tx_cg_encoder
    import pcs_tx_cg_pkg::*;
#(
    parameter int NW = NIB_W,
    parameter int CW = CG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          tx_er,
    input  logic [NW-1:0] txd,
    input  logic          bypass,
    input  logic [CW-1:0] raw_cg,
    output logic [CW-1:0] code_out
);

    txcg_state_e   state_q;
    cg_sel_e       sel;
    logic [CW-1:0] data_cg;
    logic [CW-1:0] next_cg;

    txcg_delim_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .tx_er   (tx_er),
        .bypass  (bypass),
        .state_q (state_q),
        .sel     (sel)
    );

    txcg_nibble_map #(.NW(NW), .CW(CW)) u_map (
        .nib (txd),
        .cg  (data_cg)
    );

    // Output group selection
    always_comb begin
        if (bypass) begin
            next_cg = raw_cg;
        end else begin
            unique case (sel)
                SEL_J:    next_cg = CG_J;
                SEL_K:    next_cg = CG_K;
                SEL_DATA: next_cg = data_cg;
                SEL_HALT: next_cg = CG_HALT;
                SEL_T:    next_cg = CG_T;
                SEL_R:    next_cg = CG_R;
                default:  next_cg = CG_IDLE;
            endcase
        end
    end

    txcg_out_reg #(.W(CW), .RST_VAL(CG_IDLE)) u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (next_cg),
        .q     (code_out)
    );

endmodule

// File: rtl/pcs_tx_cg_checker.sv
module pcs_tx_cg_checker
    import pcs_tx_cg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tx_en,
    input logic        tx_er,
    input logic        bypass,
    input logic [4:0]  raw_cg,
    input logic [4:0]  code_out,
    input txcg_state_e state_q
);

    p_idle_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && state_q == ST_IDLE && !tx_en) |=> code_out == CG_IDLE);

    p_j_on_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && state_q == ST_IDLE && tx_en) |=> code_out == CG_J);

    p_k_after_j_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && state_q == ST_SEND_K && tx_en) |=> code_out == CG_K);

    p_t_on_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && state_q == ST_DATA && !tx_en) |=> code_out == CG_T);

    p_r_after_t_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && state_q == ST_SEND_R) |=> code_out == CG_R);

    p_short_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && state_q == ST_SEND_K && !tx_en) |=> code_out == CG_T);

    p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && state_q == ST_DATA && tx_en && tx_er) |=> code_out == CG_HALT);

    p_bypass_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> code_out == $past(raw_cg));

    p_bypass_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> state_q == ST_IDLE);

endmodule

bind pcs_tx_cg_encoder pcs_tx_cg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .tx_er    (tx_er),
    .bypass   (bypass),
    .raw_cg   (raw_cg),
    .code_out (code_out),
    .state_q  (state_q)
);

// File: tb/pcs_tx_cg_encoder_test.sv
`timescale 1ns/1ps
module pcs_tx_cg_encoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       bypass = 1'b0;
    logic [4:0] raw_cg = 5'h0;
    logic [4:0] code_out;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [4:0] E_I = 5'b11111, E_J = 5'b11000, E_K = 5'b10001,
                           E_T = 5'b01101, E_R = 5'b00111, E_H = 5'b00100;

    always #2.5 clk = ~clk;

    pcs_tx_cg_encoder uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
        .bypass(bypass), .raw_cg(raw_cg), .code_out(code_out)
    );

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    task automatic compare(input string req, input logic [4:0] exp);
        n_cmp++;
        if (code_out !== exp) begin
            n_bad++;
            $display("FAIL %s: code_out=%b expected=%b at %0t", req, code_out, exp, $time);
        end
    endtask

    // apply inputs at negedge, check one clock later (after posedge)
    task automatic step(input logic en, input logic er, input logic [3:0] d,
                        input logic byp, input logic [4:0] raw,
                        input string req, input logic [4:0] exp);
        @(negedge clk);
        tx_en = en; tx_er = er; txd = d; bypass = byp; raw_cg = raw;
        @(posedge clk);
        #1;
        compare(req, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        compare("R1", E_I);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R1", E_I);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++)
            step(1'b0, 1'b0, 4'(i * 5), 1'b0, 5'h0, "R2", E_I);
    endtask

    task automatic send_frame(input int len, input logic [3:0] seed, input logic [3:0] stride);
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R3", E_J);
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R3", E_K);
        for (int i = 0; i < len; i++) begin
            logic [3:0] nb;
            nb = seed + 4'(i) * stride;
            step(1'b1, 1'b0, nb, 1'b0, 5'h0, "R4", enc(nb));
        end
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R5", E_T);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R5", E_R);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R5", E_I);
    endtask

    task automatic t_frames();
        send_frame(16, 4'h0, 4'h1);
        send_frame(8, 4'hF, 4'h3);
        send_frame(1, 4'hA, 4'h0);
    endtask

    task automatic t_error();
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R3", E_J);
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R3", E_K);
        step(1'b1, 1'b0, 4'h3, 1'b0, 5'h0, "R4", enc(4'h3));
        step(1'b1, 1'b1, 4'h3, 1'b0, 5'h0, "R6", E_H);
        step(1'b1, 1'b0, 4'h9, 1'b0, 5'h0, "R6", enc(4'h9));
        step(1'b0, 1'b1, 4'h0, 1'b0, 5'h0, "R5", E_T);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R5", E_R);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R2", E_I);
    endtask

    task automatic t_er_in_delim();
        step(1'b1, 1'b1, 4'h5, 1'b0, 5'h0, "R9", E_J);
        step(1'b1, 1'b1, 4'h5, 1'b0, 5'h0, "R9", E_K);
        step(1'b1, 1'b0, 4'hC, 1'b0, 5'h0, "R4", enc(4'hC));
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R5", E_T);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R5", E_R);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R2", E_I);
    endtask

    task automatic t_short();
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R3", E_J);
        step(1'b0, 1'b0, 4'h5, 1'b0, 5'h0, "R7", E_T);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R7", E_R);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R7", E_I);
    endtask

    task automatic t_back_to_back();
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R3", E_J);
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R3", E_K);
        step(1'b1, 1'b0, 4'h7, 1'b0, 5'h0, "R4", enc(4'h7));
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R5", E_T);
        step(1'b1, 1'b0, 4'h2, 1'b0, 5'h0, "R8", E_R);
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R8", E_J);
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R8", E_K);
        step(1'b1, 1'b0, 4'hE, 1'b0, 5'h0, "R4", enc(4'hE));
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R5", E_T);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R5", E_R);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R2", E_I);
    endtask

    task automatic t_bypass();
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R3", E_J);
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R3", E_K);
        step(1'b1, 1'b0, 4'h1, 1'b1, 5'b01010, "R10", 5'b01010);
        step(1'b1, 1'b1, 4'h2, 1'b1, 5'b10011, "R10", 5'b10011);
        step(1'b0, 1'b0, 4'h0, 1'b1, 5'b00000, "R10", 5'b00000);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R10", E_I);
        step(1'b1, 1'b0, 4'h5, 1'b1, 5'b11100, "R10", 5'b11100);
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R10", E_J);
        step(1'b1, 1'b0, 4'h5, 1'b0, 5'h0, "R3", E_K);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R5", E_T);
        step(1'b0, 1'b0, 4'h0, 1'b0, 5'h0, "R5", E_R);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #100000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_idle();
        t_frames();
        t_error();
        t_er_in_delim();
        t_short();
        t_back_to_back();
        t_bypass();
        finish_run();
    end

endmodule